// File: doc/BRIEF.md
# Addressed Two-Frame Byte Assembler

This block sits behind an auto-baud serial receiver that has already decoded each frame into a 3-bit address, a 4-bit nibble and the measured bit period in clock cycles. It pairs two consecutive frames into one byte. The first frame of a pair gives the low nibble and the second gives the high nibble. Both frames must carry the address set on the strap inputs, so up to eight such blocks can listen on one serial line. A pair that fails the check is dropped without any indication.

The receiver raises the frame strobe at the start of the frame's last data bit. An accepted byte is loaded into the output register half a measured bit period later, which is the mid-bit sampling point. At that moment an active-low acknowledge goes low and stays low for one full bit period. The stored byte leaves the block as eight pin values with one enable per bit. A mode input selects push-pull or inverted open-drain behaviour, and an enable input releases every pin.

Top module: `byte_pair_assembler`

## Requirements
- R1: The byte presented is {high nibble of the second frame, low nibble of the first frame}. Bit 0 of the byte is bit 0 of the first frame's nibble.
- R2: If the second frame's address differs from the first frame's address, the byte is discarded. The output register keeps its value and ack_n stays 1.
- R3: A frame that would start a pair is ignored when its address differs from strap_addr. The next matching frame is then taken as a low nibble.
- R4: With P the second frame's period (P >= 4), the output register takes the new byte on the (P>>1)-th rising clock edge after the edge that samples the second frame's strobe. It holds its old value before that edge.
- R5: ack_n goes to 0 on the same edge that loads the byte. It stays 0 for exactly P clock cycles and then returns to 1.
- R6: A frm_err pulse clears any pending low nibble. A frame strobe that arrives in the same cycle as frm_err is discarded.
- R7: After a pair is accepted or dropped, the next matching frame is taken as a new low nibble.
- R8: While rst_n is 0, the output register is 0x00, ack_n is 1 and no low nibble is pending.
- R9: When out_en is 0, every bit of pin_oe is 0 (high impedance), in both modes.
- R10: In push-pull mode (od_mode = 0) with out_en = 1, pin_oe is all ones and pin_val equals the stored byte.
- R11: In open-drain mode (od_mode = 1), pin_val is all zeros and pin_oe[i] equals stored bit i ANDed with out_en. A stored 1 therefore pulls its pin low and a stored 0 releases it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frm_valid | input | 1 | One-cycle strobe: a decoded frame is present |
| frm_err | input | 1 | One-cycle strobe: the receiver saw a framing error |
| frm_addr | input | ADDR_W (3) | Address field of the frame |
| frm_nib | input | NIB_W (4) | Data nibble of the frame |
| frm_period | input | PER_W (12) | Measured bit period in clock cycles |
| strap_addr | input | ADDR_W (3) | Address this block answers to |
| out_en | input | 1 | 1 drives the pins, 0 releases all of them |
| od_mode | input | 1 | 1 selects open-drain (inverted), 0 selects push-pull |
| pin_val | output | 2*NIB_W (8) | Value driven on each data pin |
| pin_oe | output | 2*NIB_W (8) | Per-pin drive enable |
| ack_n | output | 1 | Acknowledge, low for one bit period after an accepted byte |

## Verification
The bench builds the block with its default parameters: a 3-bit address, 4-bit nibbles and a 12-bit period field. Periods of 4, 8 and 20 cycles give half-windows of 2, 4 and 10 edges. The shortest of these exercises the tightest timer load, and the longer ones show that the load point and the acknowledge length follow the second frame's period. With only eight strap values, both a mismatch on the opening frame and a mismatch between the two frames of a pair are easy to construct. A change of strap value during the run is also within reach.

// File: rtl/bpa_pkg.sv
package bpa_pkg;
    typedef enum logic [1:0] {
        TM_IDLE = 2'd0,
        TM_WAIT = 2'd1,
        TM_ACK  = 2'd2
    } tm_state_e;
endpackage

// File: rtl/bpa_pair_tracker.sv
module bpa_pair_tracker #(
    parameter int ADDR_W = 3,
    parameter int NIB_W  = 4,
    parameter int PER_W  = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 frm_valid,
    input  logic                 frm_err,
    input  logic [ADDR_W-1:0]    frm_addr,
    input  logic [NIB_W-1:0]     frm_nib,
    input  logic [PER_W-1:0]     frm_period,
    input  logic [ADDR_W-1:0]    strap_addr,
    output logic                 acc_o,
    output logic [2*NIB_W-1:0]   byte_o,
    output logic [PER_W-1:0]     per_o
);
    localparam int BYTE_W = 2 * NIB_W;

    typedef struct packed {
        logic              have_lo;
        logic [NIB_W-1:0]  lo_nib;
        logic [ADDR_W-1:0] lo_addr;
        logic              acc;
        logic [BYTE_W-1:0] byt;
        logic [PER_W-1:0]  per;
    } trk_t;

    trk_t trk_d, trk_q;

    always_comb begin
        trk_d     = trk_q;
        trk_d.acc = 1'b0;
        if (frm_err) begin
            trk_d.have_lo = 1'b0;
        end else if (frm_valid) begin
            if (!trk_q.have_lo) begin
                if (frm_addr == strap_addr) begin
                    trk_d.have_lo = 1'b1;
                    trk_d.lo_nib  = frm_nib;
                    trk_d.lo_addr = frm_addr;
                end
            end else begin
                trk_d.have_lo = 1'b0;
                if (frm_addr == trk_q.lo_addr) begin
                    trk_d.acc = 1'b1;
                    trk_d.byt = {frm_nib, trk_q.lo_nib};
                    trk_d.per = frm_period;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) trk_q <= '0;
        else        trk_q <= trk_d;
    end

    assign acc_o  = trk_q.acc;
    assign byte_o = trk_q.byt;
    assign per_o  = trk_q.per;

    // R2
    pair_addr_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trk_q.acc |-> ($past(frm_valid) && $past(frm_addr) == $past(trk_q.lo_addr)));

    // R6
    err_clears_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frm_err |=> (!trk_q.have_lo && !trk_q.acc));
endmodule

// File: rtl/bpa_out_timer.sv
module bpa_out_timer #(
    parameter int DATA_W = 8,
    parameter int PER_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_i,
    input  logic [DATA_W-1:0] byte_i,
    input  logic [PER_W-1:0]  per_i,
    output logic [DATA_W-1:0] data_o,
    output logic              ack_n_o
);
    import bpa_pkg::*;

    localparam logic [PER_W-1:0] MIN_HALF = PER_W'(2);
    localparam logic [PER_W-1:0] ONE      = PER_W'(1);

    typedef struct packed {
        tm_state_e         st;
        logic [PER_W-1:0]  cnt;
        logic [PER_W-1:0]  per;
        logic [DATA_W-1:0] pend;
        logic [DATA_W-1:0] data;
    } tmr_t;

    tmr_t tmr_d, tmr_q;
    logic [PER_W-1:0] half_w;
    logic [PER_W-1:0] len_w;

    always_comb begin
        half_w = per_i >> 1;
        if (half_w < MIN_HALF) half_w = MIN_HALF;
        len_w = (per_i == '0) ? ONE : per_i;

        tmr_d = tmr_q;
        if (acc_i) begin
            tmr_d.st   = TM_WAIT;
            tmr_d.cnt  = half_w - MIN_HALF;
            tmr_d.pend = byte_i;
            tmr_d.per  = len_w;
        end else begin
            case (tmr_q.st)
                TM_WAIT: begin
                    if (tmr_q.cnt == '0) begin
                        tmr_d.data = tmr_q.pend;
                        tmr_d.st   = TM_ACK;
                        tmr_d.cnt  = tmr_q.per - ONE;
                    end else begin
                        tmr_d.cnt = tmr_q.cnt - ONE;
                    end
                end
                TM_ACK: begin
                    if (tmr_q.cnt == '0) tmr_d.st  = TM_IDLE;
                    else                 tmr_d.cnt = tmr_q.cnt - ONE;
                end
                default: tmr_d.st = TM_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '{st: TM_IDLE, default: '0};
        else        tmr_q <= tmr_d;
    end

    assign data_o  = tmr_q.data;
    assign ack_n_o = (tmr_q.st != TM_ACK);

    // R4
    load_with_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(tmr_q.data) |-> $fell(ack_n_o));

    // R5
    ack_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_q.st == TM_ACK) |-> (tmr_q.cnt < tmr_q.per));
endmodule

// File: rtl/bpa_pin_drive.sv
module bpa_pin_drive #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] data_i,
    input  logic              out_en,
    input  logic              od_mode,
    output logic [DATA_W-1:0] pin_val,
    output logic [DATA_W-1:0] pin_oe
);
    for (genvar gi = 0; gi < DATA_W; gi++) begin : g_pin
        always_comb begin
            if (od_mode) begin
                pin_val[gi] = 1'b0;
                pin_oe[gi]  = out_en & data_i[gi];
            end else begin
                pin_val[gi] = data_i[gi];
                pin_oe[gi]  = out_en;
            end
        end
    end
endmodule

// File: rtl/byte_pair_assembler.sv
module byte_pair_assembler #(
    parameter int ADDR_W = 3,
    parameter int NIB_W  = 4,
    parameter int PER_W  = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 frm_valid,
    input  logic                 frm_err,
    input  logic [ADDR_W-1:0]    frm_addr,
    input  logic [NIB_W-1:0]     frm_nib,
    input  logic [PER_W-1:0]     frm_period,
    input  logic [ADDR_W-1:0]    strap_addr,
    input  logic                 out_en,
    input  logic                 od_mode,
    output logic [2*NIB_W-1:0]   pin_val,
    output logic [2*NIB_W-1:0]   pin_oe,
    output logic                 ack_n
);
    localparam int DATA_W = 2 * NIB_W;

    logic              acc_w;
    logic [DATA_W-1:0] byte_w;
    logic [PER_W-1:0]  per_w;
    logic [DATA_W-1:0] data_w;

    bpa_pair_tracker #(.ADDR_W(ADDR_W), .NIB_W(NIB_W), .PER_W(PER_W)) u_trk (
        .clk        (clk),
        .rst_n      (rst_n),
        .frm_valid  (frm_valid),
        .frm_err    (frm_err),
        .frm_addr   (frm_addr),
        .frm_nib    (frm_nib),
        .frm_period (frm_period),
        .strap_addr (strap_addr),
        .acc_o      (acc_w),
        .byte_o     (byte_w),
        .per_o      (per_w)
    );

    bpa_out_timer #(.DATA_W(DATA_W), .PER_W(PER_W)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .acc_i   (acc_w),
        .byte_i  (byte_w),
        .per_i   (per_w),
        .data_o  (data_w),
        .ack_n_o (ack_n)
    );

    bpa_pin_drive #(.DATA_W(DATA_W)) u_pin (
        .data_i  (data_w),
        .out_en  (out_en),
        .od_mode (od_mode),
        .pin_val (pin_val),
        .pin_oe  (pin_oe)
    );

    // R9
    pins_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_en |-> (pin_oe == '0));

    // R11
    open_drain_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (od_mode && out_en) |-> (pin_oe == data_w && pin_val == '0));

    // R10
    push_pull_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!od_mode && out_en) |-> (pin_oe == '1 && pin_val == data_w));
endmodule

// File: tb/tb_byte_pair_assembler.sv
module tb_byte_pair_assembler;
    localparam int CLK_PERIOD = 10;
    localparam logic [2:0] STRAP = 3'd5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frm_valid = 1'b0;
    logic        frm_err = 1'b0;
    logic [2:0]  frm_addr = '0;
    logic [3:0]  frm_nib = '0;
    logic [11:0] frm_period = '0;
    logic [2:0]  strap_addr = STRAP;
    logic        out_en = 1'b1;
    logic        od_mode = 1'b0;
    logic [7:0]  pin_val;
    logic [7:0]  pin_oe;
    logic        ack_n;

    int n_chk = 0;
    int n_fail = 0;
    logic [7:0] exp_data = 8'h00;

    always #(CLK_PERIOD/2) clk = ~clk;

    byte_pair_assembler dut (
        .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid), .frm_err(frm_err),
        .frm_addr(frm_addr), .frm_nib(frm_nib), .frm_period(frm_period),
        .strap_addr(strap_addr), .out_en(out_en), .od_mode(od_mode),
        .pin_val(pin_val), .pin_oe(pin_oe), .ack_n(ack_n)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic send_frame(input logic [2:0] a, input logic [3:0] n, input logic [11:0] p);
        @(negedge clk);
        frm_valid = 1'b1; frm_addr = a; frm_nib = n; frm_period = p;
        @(negedge clk);
        frm_valid = 1'b0;
    endtask

    task automatic send_err();
        @(negedge clk);
        frm_err = 1'b1;
        @(negedge clk);
        frm_err = 1'b0;
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R8 data after reset", pin_val, 8'h00);
        chk("R8 ack after reset", ack_n, 1'b1);
        chk("R10 oe push-pull", pin_oe, 8'hFF);
    endtask

    task automatic t_timed_byte(input logic [7:0] b, input logic [11:0] p);
        int h;
        logic [7:0] old;
        h = int'(p >> 1);
        old = exp_data;
        send_frame(STRAP, b[3:0], p);
        settle(2);
        send_frame(STRAP, b[7:4], p);
        settle(h - 1);
        chk("R4 data before mid-bit", pin_val, old);
        chk("R5 ack before load", ack_n, 1'b1);
        settle(1);
        chk("R1 R4 data at mid-bit", pin_val, b);
        chk("R5 ack falls with load", ack_n, 1'b0);
        settle(int'(p) - 1);
        chk("R5 ack still low at end", ack_n, 1'b0);
        settle(1);
        chk("R5 ack released", ack_n, 1'b1);
        exp_data = b;
    endtask

    task automatic t_pair_drop();
        bit saw_ack = 1'b0;
        send_frame(STRAP, 4'h3, 12'd8);
        send_frame(STRAP ^ 3'd1, 4'h9, 12'd8);
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (ack_n == 1'b0) saw_ack = 1'b1;
        end
        chk("R2 no ack on mismatch", saw_ack, 1'b0);
        chk("R2 data kept on mismatch", pin_val, exp_data);
        send_frame(STRAP, 4'h6, 12'd8);
        send_frame(STRAP, 4'hD, 12'd8);
        settle(20);
        exp_data = 8'hD6;
        chk("R7 fresh pair after drop", pin_val, exp_data);
    endtask

    task automatic t_first_bad_addr();
        send_frame(3'd2, 4'h1, 12'd8);
        send_frame(STRAP, 4'h7, 12'd8);
        send_frame(STRAP, 4'hE, 12'd8);
        settle(20);
        exp_data = 8'hE7;
        chk("R3 foreign opening frame ignored", pin_val, exp_data);
        strap_addr = 3'd2;
        send_frame(3'd2, 4'h4, 12'd8);
        send_frame(3'd2, 4'hB, 12'd8);
        settle(20);
        exp_data = 8'hB4;
        chk("R3 new strap value matched", pin_val, exp_data);
        strap_addr = STRAP;
    endtask

    task automatic t_error_clear();
        send_frame(STRAP, 4'h2, 12'd8);
        send_err();
        send_frame(STRAP, 4'h8, 12'd8);
        send_frame(STRAP, 4'h1, 12'd8);
        settle(20);
        exp_data = 8'h18;
        chk("R6 error drops pending nibble", pin_val, exp_data);
        @(negedge clk);
        frm_valid = 1'b1; frm_err = 1'b1; frm_addr = STRAP; frm_nib = 4'hF; frm_period = 12'd8;
        @(negedge clk);
        frm_valid = 1'b0; frm_err = 1'b0;
        send_frame(STRAP, 4'h5, 12'd8);
        send_frame(STRAP, 4'hA, 12'd8);
        settle(20);
        exp_data = 8'hA5;
        chk("R6 frame with error discarded", pin_val, exp_data);
    endtask

    task automatic t_pins();
        od_mode = 1'b1;
        @(negedge clk);
        chk("R11 od values", pin_val, 8'h00);
        chk("R11 od enables", pin_oe, exp_data);
        out_en = 1'b0;
        @(negedge clk);
        chk("R9 od released", pin_oe, 8'h00);
        od_mode = 1'b0;
        @(negedge clk);
        chk("R9 pp released", pin_oe, 8'h00);
        out_en = 1'b1;
        @(negedge clk);
        chk("R10 pp values", pin_val, exp_data);
        chk("R10 pp enables", pin_oe, 8'hFF);
    endtask

    task automatic t_mid_reset();
        send_frame(STRAP, 4'hC, 12'd8);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R8 data cleared", pin_val, 8'h00);
        chk("R8 ack idle", ack_n, 1'b1);
        rst_n = 1'b1;
        exp_data = 8'h00;
        send_frame(STRAP, 4'h3, 12'd8);
        send_frame(STRAP, 4'h9, 12'd8);
        settle(20);
        exp_data = 8'h93;
        chk("R8 no pending nibble after reset", pin_val, exp_data);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        settle(3);
        t_reset();
        rst_n = 1'b1;
        settle(2);
        t_timed_byte(8'hA5, 12'd8);
        t_timed_byte(8'h3C, 12'd20);
        t_timed_byte(8'h81, 12'd4);
        t_pair_drop();
        t_first_bad_addr();
        t_error_clear();
        t_pins();
        t_mid_reset();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule